// File: doc/BRIEF.md
# 8-bit ALU with Processor Status Register

This block does the arithmetic and logic for a small 8-bit processor core and holds the processor status byte. Each cycle in which `op_valid` is high, it takes a 5-bit operation code, the accumulator value and an operand byte. It combines them with its own stored flags and computes a result byte and the next flag values. On the next rising clock edge it registers the result, a write-enable, and the new status byte. The surrounding core handles instruction decode, memory access and register routing. For the single-input operations (shifts, rotates, increment, decrement, pass), the core routes either the accumulator or a memory byte into the operand input.

The block has no sequencing control states. Each operation completes in one cycle, and the only state is the status register and the output registers. There are two phases: an idle cycle (`op_valid` low), which holds everything, and an execute cycle, which loads the outputs. Decimal arithmetic is not performed, and the decimal flag is only stored.

Top module: `alu8_status_unit`

## Requirements
- R1: After reset, `status_o` is 0x24 (interrupt-disable and bit 5 set) and `out_valid` is 0. Status bit positions are: 0 carry C, 1 zero Z, 2 interrupt disable I, 3 decimal D, 4 break, 5 always one, 6 overflow V, 7 negative N.
- R2: Add with carry (code 1) produces result = acc + opnd + C modulo 256, and sets C when the 9-bit sum exceeds 0xFF.
- R3: For add and subtract, V is set exactly when both inputs of the addition have the same sign and the result has the other sign. For subtract, the inputs are acc and the inverted operand.
- R4: Subtract with borrow (code 2) is acc + ~opnd + C. The result is acc − opnd − (1 − C), and C = 1 means no borrow occurred.
- R5: Pass (0), AND (3), OR (4) and XOR (5) write their result. Z is set when the result is 0x00, and N copies result bit 7. C and V are unchanged.
- R6: Compare (code 12) sets C when acc ≥ opnd (unsigned), and sets Z and N from acc − opnd. It does not write (`result_wr` = 0) and does not change V.
- R7: Bit test (code 13) sets Z when (acc AND opnd) = 0, copies opnd bit 7 to N and opnd bit 6 to V, does not write, and leaves C unchanged.
- R8: Shift left (6) moves opnd bit 7 to C and shifts in 0. Shift right (7) moves opnd bit 0 to C and shifts in 0. Both update Z and N from the result.
- R9: Rotate left (8) shifts the old C into bit 0 and bit 7 out to C. Rotate right (9) shifts the old C into bit 7 and bit 0 out to C. Both update Z and N from the result.
- R10: Increment (10) and decrement (11) of opnd wrap modulo 256, update Z and N, and leave C and V unchanged.
- R11: The flag operations clear C (16), set C (17), clear I (18), set I (19), clear D (20), set D (21) and clear V (22) each change only their own bit and do not write.
- R12: While `op_valid` is low the status holds. An undefined code (14, 15, 23–31) leaves the status unchanged with `result_wr` = 0. Bit 5 stays 1 and bit 4 stays 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Execute the presented operation this cycle |
| op_code | input | 5 | Operation code (see requirements) |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Operand byte |
| out_valid | output | 1 | Registered outputs hold a fresh operation result |
| result_o | output | 8 | Registered result byte |
| result_wr | output | 1 | Result is to be written back to a register |
| status_o | output | 8 | Processor status byte |

## Verification
The hardest cases to reach are those that depend on the stored flags: the carry-in of add and subtract, and the bit shifted in by rotates. The stored flags can only be set through earlier operations. The stimulus therefore places set-carry and clear-carry operations just before each such case, and it arranges add results that wrap to zero and signed overflow in both directions. The bench keeps its own flag model, so every later expectation follows from the flags the earlier operations should have left.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    typedef enum logic [4:0] {
        OP_PASS = 5'd0,  OP_ADC = 5'd1,  OP_SBC = 5'd2,  OP_AND = 5'd3,
        OP_ORA  = 5'd4,  OP_XOR = 5'd5,  OP_ASL = 5'd6,  OP_LSR = 5'd7,
        OP_ROL  = 5'd8,  OP_ROR = 5'd9,  OP_INC = 5'd10, OP_DEC = 5'd11,
        OP_CMP  = 5'd12, OP_BIT = 5'd13,
        OP_CLC  = 5'd16, OP_SEC = 5'd17, OP_CLI = 5'd18, OP_SEI = 5'd19,
        OP_CLD  = 5'd20, OP_SED = 5'd21, OP_CLV = 5'd22
    } alu_op_e;

    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_I = 2;
    localparam int FLG_D = 3;
    localparam int FLG_B = 4;
    localparam int FLG_U = 5;
    localparam int FLG_V = 6;
    localparam int FLG_N = 7;
    localparam logic [7:0] STAT_RST = 8'h24;
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] r,
    output logic          cout,
    output logic          vout
);
    localparam int SW = DW + 1;

    logic [DW-1:0] x, addend;
    logic          ci;
    logic [SW-1:0] sum;

    always_comb begin
        x      = a;
        addend = b;
        ci     = cin;
        unique case (op)
            OP_SBC: addend = ~b;
            OP_CMP: begin addend = ~b; ci = 1'b1; end
            OP_INC: begin x = b; addend = '0; ci = 1'b1; end
            OP_DEC: begin x = b; addend = '1; ci = 1'b0; end
            default: ;
        endcase
    end

    assign sum  = {1'b0, x} + {1'b0, addend} + {{(SW-1){1'b0}}, ci};
    assign r    = sum[DW-1:0];
    assign cout = sum[DW];
    assign vout = ((addend ^ r) & (r ^ x)) >> (DW - 1) != '0;
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] d,
    input  logic          cin,
    output logic [DW-1:0] r,
    output logic          cout
);
    always_comb begin
        r    = d;
        cout = cin;
        unique case (op)
            OP_ASL: begin r = {d[DW-2:0], 1'b0}; cout = d[DW-1]; end
            OP_LSR: begin r = {1'b0, d[DW-1:1]}; cout = d[0];    end
            OP_ROL: begin r = {d[DW-2:0], cin};  cout = d[DW-1]; end
            OP_ROR: begin r = {cin, d[DW-1:1]};  cout = d[0];    end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] r
);
    always_comb begin
        unique case (op)
            OP_AND, OP_BIT: r = a & b;
            OP_ORA:         r = a | b;
            OP_XOR:         r = a ^ b;
            default:        r = b;
        endcase
    end
endmodule

// File: rtl/alu8_status_unit.sv
module alu8_status_unit
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [4:0]    op_code,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] opnd_in,
    output logic          out_valid,
    output logic [DW-1:0] result_o,
    output logic          result_wr,
    output logic [7:0]    status_o
);
    alu_op_e       op_e;
    logic [DW-1:0] add_r, sh_r, log_r, res_d;
    logic          add_c, add_v, sh_c, wr_d;
    logic [7:0]    stat_d;

    assign op_e = alu_op_e'(op_code);

    alu8_adder #(.DW(DW)) adder_i (
        .op(op_e), .a(acc_in), .b(opnd_in), .cin(status_o[FLG_C]),
        .r(add_r), .cout(add_c), .vout(add_v)
    );

    alu8_shifter #(.DW(DW)) shifter_i (
        .op(op_e), .d(opnd_in), .cin(status_o[FLG_C]),
        .r(sh_r), .cout(sh_c)
    );

    alu8_logic #(.DW(DW)) logic_i (
        .op(op_e), .a(acc_in), .b(opnd_in), .r(log_r)
    );

    always_comb begin
        stat_d = status_o;
        res_d  = acc_in;
        wr_d   = 1'b0;
        unique case (op_e)
            OP_ADC, OP_SBC: begin
                res_d = add_r; wr_d = 1'b1;
                stat_d[FLG_C] = add_c;
                stat_d[FLG_V] = add_v;
            end
            OP_INC, OP_DEC: begin
                res_d = add_r; wr_d = 1'b1;
            end
            OP_CMP: begin
                stat_d[FLG_C] = add_c;
            end
            OP_PASS, OP_AND, OP_ORA, OP_XOR: begin
                res_d = log_r; wr_d = 1'b1;
            end
            OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
                res_d = sh_r; wr_d = 1'b1;
                stat_d[FLG_C] = sh_c;
            end
            OP_BIT: begin
                stat_d[FLG_V] = opnd_in[DW-2];
            end
            OP_CLC: stat_d[FLG_C] = 1'b0;
            OP_SEC: stat_d[FLG_C] = 1'b1;
            OP_CLI: stat_d[FLG_I] = 1'b0;
            OP_SEI: stat_d[FLG_I] = 1'b1;
            OP_CLD: stat_d[FLG_D] = 1'b0;
            OP_SED: stat_d[FLG_D] = 1'b1;
            OP_CLV: stat_d[FLG_V] = 1'b0;
            default: ;
        endcase
        // zero and negative flags
        if (wr_d) begin
            stat_d[FLG_Z] = (res_d == '0);
            stat_d[FLG_N] = res_d[DW-1];
        end else if (op_e == OP_CMP) begin
            stat_d[FLG_Z] = (add_r == '0);
            stat_d[FLG_N] = add_r[DW-1];
        end else if (op_e == OP_BIT) begin
            stat_d[FLG_Z] = (log_r == '0);
            stat_d[FLG_N] = opnd_in[DW-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_o  <= STAT_RST;
            result_o  <= '0;
            result_wr <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= op_valid;
            if (op_valid) begin
                status_o  <= stat_d;
                result_o  <= res_d;
                result_wr <= wr_d;
            end
        end
    end

    p_fixed_bits_r12: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[FLG_U] && !status_o[FLG_B]);

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(status_o));

    p_cmp_keeps_v_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 5'd12) |=> (status_o[FLG_V] == $past(status_o[FLG_V]) && !result_wr));

    p_incdec_cv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 5'd10 || op_code == 5'd11))
        |=> (status_o[FLG_C] == $past(status_o[FLG_C]) && status_o[FLG_V] == $past(status_o[FLG_V])));

    p_bit_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 5'd13) |=> (!result_wr && status_o[FLG_C] == $past(status_o[FLG_C])));
endmodule

// File: tb/alu8_status_unit_tb_top.sv
module alu8_status_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_code = '0;
    logic [7:0] acc_in = '0, opnd_in = '0;
    logic       out_valid, result_wr;
    logic [7:0] result_o, status_o;

    int checks = 0, failures = 0;
    logic [7:0] mstat;

    typedef struct {
        logic [7:0] res;
        logic       wr;
        logic [7:0] st;
        string      tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    alu8_status_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .acc_in(acc_in), .opnd_in(opnd_in), .out_valid(out_valid),
        .result_o(result_o), .result_wr(result_wr), .status_o(status_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected behaviour derived from the requirements
    task automatic model(input int op, input logic [7:0] a, input logic [7:0] m, output item_t it);
        logic [7:0] s, r;
        logic w;
        int t;
        s = mstat; r = a; w = 1'b0;
        case (op)
            1: begin
                t = int'(a) + int'(m) + int'(s[0]); r = t[7:0]; w = 1;
                s[0] = (t > 255); s[6] = (a[7] == m[7]) && (r[7] != a[7]);
            end
            2: begin
                t = int'(a) - int'(m) - (1 - int'(s[0])); r = t[7:0]; w = 1;
                s[0] = (t >= 0); s[6] = (a[7] != m[7]) && (r[7] != a[7]);
            end
            0: begin r = m; w = 1; end
            3: begin r = a & m; w = 1; end
            4: begin r = a | m; w = 1; end
            5: begin r = a ^ m; w = 1; end
            6: begin r = m << 1; s[0] = m[7]; w = 1; end
            7: begin r = m >> 1; s[0] = m[0]; w = 1; end
            8: begin r = {m[6:0], s[0]}; s[0] = m[7]; w = 1; end
            9: begin r = {s[0], m[7:1]}; s[0] = m[0]; w = 1; end
            10: begin r = m + 8'd1; w = 1; end
            11: begin r = m - 8'd1; w = 1; end
            12: begin s[0] = (a >= m); s[1] = (a == m); s[7] = ((a - m) >> 7) != 0; end
            13: begin s[1] = ((a & m) == 0); s[7] = m[7]; s[6] = m[6]; end
            16: s[0] = 0;
            17: s[0] = 1;
            18: s[2] = 0;
            19: s[2] = 1;
            20: s[3] = 0;
            21: s[3] = 1;
            22: s[6] = 0;
            default: ;
        endcase
        if (w) begin s[1] = (r == 0); s[7] = r[7]; end
        mstat = s;
        it.res = r; it.wr = w; it.st = s;
    endtask

    // driver: presents one operation and queues its expected outcome
    task automatic drive(input string tag, input int op, input logic [7:0] a, input logic [7:0] m);
        item_t it;
        @(negedge clk);
        op_valid = 1'b1; op_code = op[4:0]; acc_in = a; opnd_in = m;
        model(op, a, m, it);
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_valid = 1'b0;
            op_code = 5'd17; acc_in = 8'hFF; opnd_in = 8'hFF;
        end
    endtask

    // monitor: compares registered results against the queue
    initial begin
        forever begin
            @(negedge clk);
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check("SB unexpected output", 1, 0);
                end else begin
                    item_t e;
                    e = sb.pop_front();
                    check({e.tag, " result"}, result_o, e.res);
                    check({e.tag, " write"}, result_wr, e.wr);
                    check({e.tag, " status"}, status_o, e.st);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        check("watchdog expired", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        mstat = 8'h24;
        #35;
        check("R1 reset status", status_o, 8'h24);
        check("R1 reset out_valid", out_valid, 0);
        rst_n = 1'b1;
        drive("R11 clc", 16, 8'h00, 8'h00);
        drive("R3 adc signed overflow", 1, 8'h50, 8'h50);
        drive("R2 adc wrap to zero", 1, 8'hFF, 8'h01);
        drive("R2 adc with carry in", 1, 8'h10, 8'h20);
        drive("R11 sec", 17, 8'h00, 8'h00);
        drive("R4 sbc no borrow", 2, 8'h05, 8'h03);
        drive("R4 sbc borrow", 2, 8'h03, 8'h05);
        drive("R4 sbc carry clear", 2, 8'h05, 8'h03);
        drive("R11 sec", 17, 8'h00, 8'h00);
        drive("R3 sbc signed overflow", 2, 8'h80, 8'h01);
        drive("R5 and", 3, 8'hF0, 8'h0F);
        drive("R5 ora", 4, 8'h80, 8'h01);
        drive("R5 xor", 5, 8'h5A, 8'hFF);
        drive("R5 pass zero", 0, 8'h77, 8'h00);
        drive("R6 cmp equal", 12, 8'h40, 8'h40);
        drive("R6 cmp greater", 12, 8'h41, 8'h40);
        drive("R6 cmp less", 12, 8'h10, 8'h20);
        drive("R7 bit", 13, 8'h0F, 8'hC0);
        drive("R7 bit nonzero", 13, 8'h01, 8'h01);
        drive("R8 asl", 6, 8'h00, 8'h81);
        drive("R8 lsr", 7, 8'h00, 8'h01);
        drive("R11 sec", 17, 8'h00, 8'h00);
        drive("R9 rol carry in", 8, 8'h00, 8'h40);
        drive("R11 sec", 17, 8'h00, 8'h00);
        drive("R9 ror carry in", 9, 8'h00, 8'h02);
        drive("R9 rol carry out", 8, 8'h00, 8'h80);
        drive("R3 adc set v", 1, 8'h7F, 8'h01);
        drive("R10 inc wrap", 10, 8'h00, 8'hFF);
        drive("R10 dec wrap", 11, 8'h00, 8'h00);
        drive("R11 sei", 19, 8'h00, 8'h00);
        drive("R11 cli", 18, 8'h00, 8'h00);
        drive("R11 sed", 21, 8'h00, 8'h00);
        drive("R11 cld", 20, 8'h00, 8'h00);
        drive("R11 clv", 22, 8'h00, 8'h00);
        drive("R12 undefined code", 31, 8'h12, 8'h34);
        drive("R12 undefined code 14", 14, 8'h00, 8'h00);
        idle(4);
        check("R12 idle hold status", status_o, mstat);
        check("R12 idle queue drained", sb.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule